// File: doc/BRIEF.md
# Dual DAC Serial Word Writer

This block sends one parallel 8-bit sample to a dual 8-bit voltage-output converter over three wires: an active-low frame sync, a serial clock and a serial data line. A one-cycle start strobe captures the sample together with a channel select, a reference choice, an update mode and a power-down code. These are packed into a 16-bit word: a control byte followed by the data byte. The word is then shifted out, most significant bit first, and the converter samples each bit on a rising serial clock edge.

The serial clock is derived from the system clock by a parameterised half-period divider. With a 50 MHz system clock and the default divider of one, the serial clock runs at 25 MHz and a whole frame takes 34 system cycles, which is 680 ns, or about 1.47 million updates per second. The converter's output voltage is 2·VREF·N/256 for code N. The block only forwards the reference choice as a control bit and does no scaling.

Top module: `dacw_serial_tx`

## Requirements
- R1: Out of reset and between frames, sync_no and sclk_o are high, and sdin_o, busy_o and done_o are low.
- R2: The control byte is {ref_ext_i, 0, pdn_i[1:0], upd_mode_i[1:0], 0, chan_i}, with bit 7 first. The frame word is {control byte, data_i}.
- R3: The word leaves on sdin_o MSB first, control byte first. sdin_o holds steady while sclk_o is high and changes only while sclk_o is low, so each rising sclk_o edge samples exactly one bit.
- R4: A frame holds sync_no low for 34·HALF_DIV system cycles. sclk_o stays high for the first and the last HALF_DIV cycles of the frame and has exactly 16 rising edges in between.
- R5: A start_i pulse that arrives while busy_o is high is ignored. It changes neither the word being sent nor the frame length, and no extra frame follows it.
- R6: busy_o is high exactly while sync_no is low. done_o is a one-cycle pulse in the first cycle in which sync_no is high again.
- R7: A start_i pulse in the cycle in which done_o is high is accepted, and the next frame begins in the following cycle.
- R8: Each low and each high phase of sclk_o lasts HALF_DIV system cycles. The block checks at elaboration that CLK_HZ/(2·HALF_DIV) does not exceed SCLK_MAX_HZ (30 MHz by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send a word |
| data_i | input | 8 | Sample code for the converter |
| chan_i | input | 1 | Channel select (0 or 1) |
| ref_ext_i | input | 1 | Reference choice bit |
| upd_mode_i | input | 2 | Update mode field of the control byte |
| pdn_i | input | 2 | Power-down field of the control byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Pulse when the frame sync is released |
| sync_no | output | 1 | Frame sync, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdin_o | output | 1 | Serial data |

## Verification
The assertions check every cycle that the lines are idle when no frame runs, that done is a single pulse that follows the end of busy, that the step counter stays in range, that data is stable at each rising serial clock edge, and that an accepted start opens a frame with the clock high. Only the bench's scenarios can show that the captured word matches the packed fields bit for bit, that the frame and clock-phase lengths match the divider, that a mid-frame start leaves the frame untouched, and that a start in the done cycle chains a new frame with no gap.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  typedef struct packed {
    logic       ref_ext;
    logic       rsv_hi;
    logic [1:0] pdn;
    logic [1:0] upd_mode;
    logic       rsv_lo;
    logic       chan;
  } dac_ctrl_t;

  localparam int unsigned CTRL_W = $bits(dac_ctrl_t);

  function automatic dac_ctrl_t make_ctrl(input logic chan, input logic ref_ext,
                                          input logic [1:0] upd_mode,
                                          input logic [1:0] pdn);
    dac_ctrl_t c;
    c.ref_ext  = ref_ext;
    c.rsv_hi   = 1'b0;
    c.pdn      = pdn;
    c.upd_mode = upd_mode;
    c.rsv_lo   = 1'b0;
    c.chan     = chan;
    return c;
  endfunction

endpackage

// File: rtl/dacw_tick.sv
module dacw_tick #(
  parameter int unsigned HALF_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

endmodule

// File: rtl/dacw_seq.sv
module dacw_seq #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic shift_o,
  output logic sclk_o,
  output logic sync_no
);
  // step 0: lead (clock high), 1..2*WORD_W: low/high pairs, last: trail
  localparam int unsigned LAST   = 2 * WORD_W + 1;
  localparam int unsigned STEP_W = $clog2(LAST + 1);
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(LAST);
  localparam logic [STEP_W-1:0] SHIFT_HI   = STEP_W'(2 * WORD_W - 2);

  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic              done_q;
  logic              at_end;

  assign at_end  = busy_q && tick_i && (step_q == STEP_LAST);
  assign load_o  = start_i && !busy_q;
  assign shift_o = busy_q && tick_i && !step_q[0] &&
                   (step_q >= STEP_W'(2)) && (step_q <= SHIFT_HI);
  assign sclk_o  = !(busy_q && step_q[0] && (step_q != STEP_LAST));
  assign sync_no = !busy_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= at_end;
      if (load_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (at_end) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else if (busy_q && tick_i) begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o && sync_no));
  p_step_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_LAST);

endmodule

// File: rtl/dacw_shift.sv
module dacw_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdin_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign sdin_o = busy_i && sh_q[WORD_W-1];

  p_no_load_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && busy_i));

endmodule

// File: rtl/dacw_serial_tx.sv
module dacw_serial_tx #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SCLK_MAX_HZ = 30_000_000,
  parameter int unsigned HALF_DIV    = 1,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              chan_i,
  input  logic              ref_ext_i,
  input  logic [1:0]        upd_mode_i,
  input  logic [1:0]        pdn_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sync_no,
  output logic              sclk_o,
  output logic              sdin_o
);
  import dacw_pkg::*;

  localparam int unsigned WORD_W = CTRL_W + DATA_W;

  initial begin
    p_sclk_limit_r8: assert (longint'(CLK_HZ) <= 2 * longint'(HALF_DIV) * longint'(SCLK_MAX_HZ))
      else $error("serial clock above limit: raise HALF_DIV");
  end

  logic              tick;
  logic              load;
  logic              shift;
  logic [WORD_W-1:0] word;

  assign word = {make_ctrl(chan_i, ref_ext_i, upd_mode_i, pdn_i), data_i};

  dacw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  dacw_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (tick),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .shift_o (shift),
    .sclk_o  (sclk_o),
    .sync_no (sync_no)
  );

  dacw_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .busy_i  (busy_o),
    .word_i  (word),
    .sdin_o  (sdin_o)
  );

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $rose(sclk_o)) |-> $stable(sdin_o));
  p_start_opens_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !sync_no && sclk_o));
  p_idle_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_no |-> !sdin_o);

endmodule

// File: tb/dacw_serial_tx_test.sv
module dacw_serial_tx_test;
  localparam int HALF = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       chan_i = 1'b0;
  logic       ref_ext_i = 1'b0;
  logic [1:0] upd_mode_i = '0;
  logic [1:0] pdn_i = '0;
  logic       busy_o, done_o, sync_no, sclk_o, sdin_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  dacw_serial_tx #(.HALF_DIV(HALF)) uut (
    .clk_i, .rst_ni, .start_i, .data_i, .chan_i, .ref_ext_i,
    .upd_mode_i, .pdn_i, .busy_o, .done_o, .sync_no, .sclk_o, .sdin_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(sync_no == 1'b1, {req, " sync idle"}, sync_no, 1);
    chk(sclk_o == 1'b1, {req, " sclk idle"}, sclk_o, 1);
    chk({sdin_o, busy_o, done_o} == 3'b000, {req, " sdin/busy/done idle"},
        {sdin_o, busy_o, done_o}, 0);
  endtask

  // caller is at a falling edge; drives start and follows the frame
  task automatic do_frame(input logic [7:0] d, input logic ch, input logic rf,
                          input logic [1:0] upd, input logic [1:0] pdn,
                          input int poke_at, input string tag);
    logic [15:0] exp_w, got_w;
    int sync_low, sclk_low, nbits, busy_viol, hold_viol;
    bit prev_sclk, prev_sdin, released, saw_done;
    exp_w = {rf, 1'b0, pdn, upd, 1'b0, ch, d};   // R2 layout
    got_w = '0;
    sync_low = 0; sclk_low = 0; nbits = 0; busy_viol = 0; hold_viol = 0;
    prev_sclk = 1'b1; prev_sdin = 1'b0; released = 1'b0; saw_done = 1'b0;
    data_i = d; chan_i = ch; ref_ext_i = rf; upd_mode_i = upd; pdn_i = pdn;
    start_i = 1'b1;
    for (int j = 0; j < 400; j++) begin
      @(negedge clk_i);
      if (j == 0) start_i = 1'b0;
      if (sync_no) begin
        released = 1'b1;
        saw_done = done_o;
        chk(busy_o == 1'b0, {tag, " R6 busy low at release"}, busy_o, 0);
        break;
      end
      sync_low++;
      if (busy_o !== 1'b1) busy_viol++;
      if (!sclk_o) sclk_low++;
      if (sclk_o && !prev_sclk) begin
        got_w = {got_w[14:0], sdin_o};
        nbits++;
      end
      if (sclk_o && prev_sclk && j > 0 && sdin_o != prev_sdin) hold_viol++;
      prev_sclk = sclk_o;
      prev_sdin = sdin_o;
      if (j == poke_at) begin
        start_i = 1'b1; data_i = ~d; chan_i = ~ch; pdn_i = ~pdn;
      end
      if (j == poke_at + 1) begin
        start_i = 1'b0; data_i = d; chan_i = ch; pdn_i = pdn;
      end
    end
    chk(released, {tag, " R4 frame ends"}, released, 1);
    chk(got_w == exp_w, {tag, " R2/R3 word"}, got_w, exp_w);
    chk(nbits == 16, {tag, " R4 rising edges"}, nbits, 16);
    chk(sync_low == 34 * HALF, {tag, " R4 sync low cycles"}, sync_low, 34 * HALF);
    chk(sclk_low == 16 * HALF, {tag, " R8 sclk low cycles"}, sclk_low, 16 * HALF);
    chk(busy_viol == 0, {tag, " R6 busy during frame"}, busy_viol, 0);
    chk(hold_viol == 0, {tag, " R3 data hold while sclk high"}, hold_viol, 0);
    chk(saw_done, {tag, " R6 done at release"}, saw_done, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after reset");
  endtask

  task automatic t_basic();
    do_frame(8'hA5, 1'b0, 1'b0, 2'b01, 2'b00, -1, "basic");
    @(negedge clk_i);
    chk_idle("R1 R6 after basic");
  endtask

  task automatic t_fields();
    do_frame(8'h3C, 1'b1, 1'b1, 2'b10, 2'b11, -1, "fields");
    @(negedge clk_i);
    chk_idle("R1 after fields");
    do_frame(8'hFF, 1'b1, 1'b1, 2'b11, 2'b11, -1, "ones");
    @(negedge clk_i);
    do_frame(8'h00, 1'b0, 1'b0, 2'b00, 2'b00, -1, "zeros");
    @(negedge clk_i);
    chk_idle("R1 after zeros");
  endtask

  task automatic t_busy_ignored();
    do_frame(8'h81, 1'b0, 1'b1, 2'b01, 2'b10, 5, "R5 ignore");
    repeat (2) begin
      @(negedge clk_i);
      chk_idle("R5 no extra frame");
    end
  endtask

  task automatic t_back_to_back();
    do_frame(8'h5A, 1'b1, 1'b0, 2'b00, 2'b01, -1, "R7 first");
    do_frame(8'hC3, 1'b0, 1'b1, 2'b10, 2'b00, -1, "R7 chained");
    @(negedge clk_i);
    chk_idle("R7 after chain");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fields();
    t_busy_ignored();
    t_back_to_back();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule